// File: doc/BRIEF.md
# Edge-Detect Change Interrupt Controller

This block watches a bank of 8-bit digital input ports and raises a level interrupt when a selected channel makes a transition. Each channel can be armed for rising transitions, falling transitions or both, through two mask bytes per port. A control byte holds the global enables for detection, for each edge polarity, for the overflow interrupt and for the interrupt line. A status byte reports what is pending and which polarity caused the most recent event. A separate write-one-to-clear byte acknowledges the pending causes.

The pins are asynchronous to the block clock. Each pin is synchronised through two flops and then compared with its previous synchronised value. An enabled transition that arrives while an earlier one is still unacknowledged sets an overflow flag. The host reaches every register through a plain byte-wide bus. A write takes effect at the clock edge where `bus_wr` is high. A read returns, in the same cycle, the byte at `bus_addr`.

Top module: `edge_change_irq`

## Requirements
- R1: After reset, every mask byte, the control byte and the status byte read 0x00, and `irq` is low.
- R2: A rising transition on a channel counts as an event when three things are set: its rise mask bit, control bit 0 (detect) and control bit 3 (rising). The event sets status bit 0 (pending) and status bit 3 (last cause rising), and clears status bit 4. The status shows it after the third clock edge that follows the pin change.
- R3: A falling transition counts as an event under the same conditions, using the fall mask bit and control bit 4 (falling). The event sets status bit 0 and status bit 4, and clears status bit 3.
- R4: Channel n belongs to port n/8, at bit n mod 8 of that port's masks. The rise mask of port p is at address 0x42 + 0x10*p and the fall mask at 0x43 + 0x10*p. Both read back as written.
- R5: No event is recorded for a transition on an unmasked channel, for a transition of the polarity that is not armed, or for a transition that arrives while the matching global enable is low.
- R6: An event that arrives while status bit 0 is already set also sets status bit 1 (overflow).
- R7: Writing to the clear byte at 0x01 acknowledges pending causes. Bit 3 clears the pending flag and both last-cause flags. Bit 2 clears the overflow flag. The other bits have no effect. An event in the same cycle wins over the clear.
- R8: `irq` and status bit 2 equal control bit 2 AND (pending OR (control bit 1 AND overflow)).
- R9: Writing 0x00 to the control byte at 0x03 drops `irq` at once and stops new events. Pending flags are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | NUM_PORTS*8 | Asynchronous digital inputs, channel n at bit n |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt request |

## Verification
The bound checker checks several rules on every cycle. An internal event must set the pending flag, and a second event must set overflow. An acknowledge with no competing event must clear. Pending cannot appear without an event. Detection stays silent while its enable is low, and the interrupt drops whenever the master enable is off. The checker cannot see whether the mask decode picks the right port and bit, or whether the three-edge synchroniser latency is right, or how the last-cause flags read. Only the bench's scenarios show these, through a behavioural model compared with `irq` and the status byte every cycle.

// File: rtl/edc_pkg.sv
package edc_pkg;
  localparam int BYTE_W = 8;

  localparam logic [7:0] A_CLEAR  = 8'h01;
  localparam logic [7:0] A_STATUS = 8'h02;
  localparam logic [7:0] A_CTRL   = 8'h03;
  localparam int PORT_BASE   = 'h40;
  localparam int PORT_STRIDE = 'h10;
  localparam int OFS_RISE    = 2;
  localparam int OFS_FALL    = 3;

  // acknowledge bit positions in the clear byte
  localparam int K_OVF  = 2;
  localparam int K_EDGE = 3;

  // control byte, bit 0 at the right
  typedef struct packed {
    logic fall_en;
    logic rise_en;
    logic master_en;
    logic ovf_en;
    logic edge_en;
  } ctrl_t;

  // status byte, bit 0 at the right
  typedef struct packed {
    logic last_fall;
    logic last_rise;
    logic irq;
    logic ovf_pend;
    logic edge_pend;
  } stat_t;

  function automatic logic [7:0] rise_addr(input int p);
    int a;
    a = PORT_BASE + PORT_STRIDE * p + OFS_RISE;
    return a[7:0];
  endfunction

  function automatic logic [7:0] fall_addr(input int p);
    int a;
    a = PORT_BASE + PORT_STRIDE * p + OFS_FALL;
    return a[7:0];
  endfunction

  // transitions of one polarity that pass the masks and gates
  function automatic logic hits(input logic [63:0] now_v, input logic [63:0] old_v,
                                input logic [63:0] mask, input logic gate);
    return gate && ((now_v & ~old_v & mask) != 64'd0);
  endfunction
endpackage

// File: rtl/edc_sync.sv
module edc_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] cur,
  output logic [W-1:0] prv
);
  logic [W-1:0] meta_q;
  logic [W-1:0] cur_q;
  logic [W-1:0] prv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      cur_q  <= '0;
      prv_q  <= '0;
    end else begin
      meta_q <= din;
      cur_q  <= meta_q;
      prv_q  <= cur_q;
    end
  end

  assign cur = cur_q;
  assign prv = prv_q;
endmodule

// File: rtl/edc_port_regs.sv
module edc_port_regs import edc_pkg::*; #(
  parameter int NUM_PORTS = 4,
  parameter int ADDR_W    = 8,
  localparam int NCH      = NUM_PORTS * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [NCH-1:0]    rise_mask,
  output logic [NCH-1:0]    fall_mask,
  output logic              rd_hit,
  output logic [7:0]        rd_data
);
  logic [7:0] rise_m [NUM_PORTS];
  logic [7:0] fall_m [NUM_PORTS];

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rise_m[p] <= '0;
        fall_m[p] <= '0;
      end else if (wr) begin
        if (addr == ADDR_W'(rise_addr(p))) rise_m[p] <= wdata;
        if (addr == ADDR_W'(fall_addr(p))) fall_m[p] <= wdata;
      end
    end
    assign rise_mask[p*BYTE_W +: BYTE_W] = rise_m[p];
    assign fall_mask[p*BYTE_W +: BYTE_W] = fall_m[p];
  end

  always_comb begin
    rd_hit  = 1'b0;
    rd_data = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (addr == ADDR_W'(rise_addr(p))) begin
        rd_hit  = 1'b1;
        rd_data = rise_m[p];
      end
      if (addr == ADDR_W'(fall_addr(p))) begin
        rd_hit  = 1'b1;
        rd_data = fall_m[p];
      end
    end
  end
endmodule

// File: rtl/edc_events.sv
module edc_events import edc_pkg::*; (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  any_rise,
  input  logic  any_fall,
  input  logic  clr_edge,
  input  logic  clr_ovf,
  input  ctrl_t ctrl,
  output stat_t stat
);
  logic edge_pend_q, ovf_pend_q, last_rise_q, last_fall_q;
  logic evt;

  assign evt = any_rise | any_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_pend_q <= 1'b0;
      ovf_pend_q  <= 1'b0;
      last_rise_q <= 1'b0;
      last_fall_q <= 1'b0;
    end else begin
      if (evt && edge_pend_q) ovf_pend_q <= 1'b1;
      else if (clr_ovf)       ovf_pend_q <= 1'b0;

      if (evt) begin
        edge_pend_q <= 1'b1;
        last_rise_q <= any_rise;
        last_fall_q <= any_fall;
      end else if (clr_edge) begin
        edge_pend_q <= 1'b0;
        last_rise_q <= 1'b0;
        last_fall_q <= 1'b0;
      end
    end
  end

  assign stat.edge_pend = edge_pend_q;
  assign stat.ovf_pend  = ovf_pend_q;
  assign stat.last_rise = last_rise_q;
  assign stat.last_fall = last_fall_q;
  assign stat.irq       = ctrl.master_en & (edge_pend_q | (ctrl.ovf_en & ovf_pend_q));
endmodule

// File: rtl/edge_change_irq.sv
module edge_change_irq import edc_pkg::*; #(
  parameter int NUM_PORTS = 4,
  parameter int ADDR_W    = 8,
  localparam int NCH      = NUM_PORTS * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    pin_in,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              irq
);
  logic [NCH-1:0] cur, prv, rise_mask, fall_mask;
  logic           port_hit;
  logic [7:0]     port_rd;
  ctrl_t          ctrl_q;
  stat_t          stat;
  logic           any_rise, any_fall;
  logic           edge_evt, clr_edge, clr_ovf, wr_clear;
  logic           edge_pend, ovf_pend, master_en, edge_en;

  edc_sync #(.W(NCH)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pin_in), .cur(cur), .prv(prv)
  );

  edc_port_regs #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .rise_mask(rise_mask), .fall_mask(fall_mask),
    .rd_hit(port_hit), .rd_data(port_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                          ctrl_q <= '0;
    else if (bus_wr && bus_addr == ADDR_W'(A_CTRL))      ctrl_q <= ctrl_t'(bus_wdata[4:0]);
  end

  assign any_rise = hits(64'(cur), 64'(prv), 64'(rise_mask), ctrl_q.edge_en & ctrl_q.rise_en);
  assign any_fall = hits(64'(~cur), 64'(~prv), 64'(fall_mask), ctrl_q.edge_en & ctrl_q.fall_en);

  assign wr_clear = bus_wr && (bus_addr == ADDR_W'(A_CLEAR));
  assign clr_edge = wr_clear & bus_wdata[K_EDGE];
  assign clr_ovf  = wr_clear & bus_wdata[K_OVF];

  edc_events u_evt (
    .clk(clk), .rst_n(rst_n), .any_rise(any_rise), .any_fall(any_fall),
    .clr_edge(clr_edge), .clr_ovf(clr_ovf), .ctrl(ctrl_q), .stat(stat)
  );

  // named internal events for the checker
  assign edge_evt  = any_rise | any_fall;
  assign edge_pend = stat.edge_pend;
  assign ovf_pend  = stat.ovf_pend;
  assign master_en = ctrl_q.master_en;
  assign edge_en   = ctrl_q.edge_en;
  assign irq       = stat.irq;

  always_comb begin
    if (bus_addr == ADDR_W'(A_STATUS))    bus_rdata = {3'b000, stat};
    else if (bus_addr == ADDR_W'(A_CTRL)) bus_rdata = {3'b000, ctrl_q};
    else if (port_hit)                    bus_rdata = port_rd;
    else                                  bus_rdata = 8'h00;
  end
endmodule

// File: rtl/edge_change_irq_chk.sv
module edge_change_irq_chk (
  input logic clk,
  input logic rst_n,
  input logic irq,
  input logic edge_evt,
  input logic clr_edge,
  input logic clr_ovf,
  input logic edge_pend,
  input logic ovf_pend,
  input logic master_en,
  input logic edge_en
);
  AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!edge_pend && !ovf_pend && !irq)); // R1
  AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    edge_evt |=> edge_pend); // R2
  AST_DETECT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !edge_en |-> !edge_evt); // R5
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_evt && !edge_pend) |=> !edge_pend); // R5
  AST_OVERFLOW_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_evt && edge_pend) |=> ovf_pend); // R6
  AST_EDGE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_edge && !edge_evt) |=> !edge_pend); // R7
  AST_OVF_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ovf && !(edge_evt && edge_pend)) |=> !ovf_pend); // R7
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (edge_pend || ovf_pend)); // R8
  AST_MASTER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !master_en |-> !irq); // R9
endmodule

bind edge_change_irq edge_change_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .edge_evt(edge_evt),
  .clr_edge(clr_edge), .clr_ovf(clr_ovf), .edge_pend(edge_pend),
  .ovf_pend(ovf_pend), .master_en(master_en), .edge_en(edge_en)
);

// File: tb/edge_change_irq_test.sv
`timescale 1ns/100ps
module edge_change_irq_test;
  localparam int NUM_PORTS = 4;
  localparam int NCH = NUM_PORTS * 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NCH-1:0] pin_in = '0;
  logic           bus_wr = 1'b0;
  logic [7:0]     bus_addr = 8'h02;
  logic [7:0]     bus_wdata = 8'h00;
  logic [7:0]     bus_rdata;
  logic           irq;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  edge_change_irq #(.NUM_PORTS(NUM_PORTS), .ADDR_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // behavioural reference model
  logic [7:0]     m_rise [NUM_PORTS];
  logic [7:0]     m_fall [NUM_PORTS];
  logic [4:0]     m_ctrl;
  bit             m_pend, m_ovf, m_lr, m_lf;
  logic [NCH-1:0] samp [$];
  logic [NCH-1:0] newer, older;
  bit             r_hit, f_hit, ack_e, ack_o;
  int             rel;

  function automatic bit m_irq();
    return m_ctrl[2] && (m_pend || (m_ctrl[1] && m_ovf));
  endfunction

  function automatic logic [7:0] m_status();
    return {3'b000, m_lf, m_lr, m_irq(), m_ovf, m_pend};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < NUM_PORTS; p++) begin m_rise[p] = 0; m_fall[p] = 0; end
      m_ctrl = 0; m_pend = 0; m_ovf = 0; m_lr = 0; m_lf = 0;
      samp.delete();
    end else begin
      newer = (samp.size() > 1) ? samp[1] : '0;
      older = (samp.size() > 2) ? samp[2] : '0;
      r_hit = 0; f_hit = 0;
      for (int ch = 0; ch < NCH; ch++) begin
        if (m_ctrl[0] && m_ctrl[3] && newer[ch] && !older[ch] && m_rise[ch/8][ch%8]) r_hit = 1;
        if (m_ctrl[0] && m_ctrl[4] && !newer[ch] && older[ch] && m_fall[ch/8][ch%8]) f_hit = 1;
      end
      ack_e = bus_wr && bus_addr == 8'h01 && bus_wdata[3];
      ack_o = bus_wr && bus_addr == 8'h01 && bus_wdata[2];
      if ((r_hit || f_hit) && m_pend) m_ovf = 1;
      else if (ack_o) m_ovf = 0;
      if (r_hit || f_hit) begin m_pend = 1; m_lr = r_hit; m_lf = f_hit; end
      else if (ack_e) begin m_pend = 0; m_lr = 0; m_lf = 0; end
      if (bus_wr) begin
        if (bus_addr == 8'h03) m_ctrl = bus_wdata[4:0];
        if (bus_addr >= 8'h40) begin
          rel = int'(bus_addr) - 'h40;
          if (rel / 16 < NUM_PORTS && rel % 16 == 2) m_rise[rel/16] = bus_wdata;
          if (rel / 16 < NUM_PORTS && rel % 16 == 3) m_fall[rel/16] = bus_wdata;
        end
      end
      samp.push_front(pin_in);
      if (samp.size() > 3) void'(samp.pop_back());
    end
  end

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_checks++;
      if (irq !== m_irq()) begin
        n_fail++;
        $display("FAIL R8 model irq: actual %0b expected %0b at %0t", irq, m_irq(), $time);
      end
      if (!bus_wr && bus_addr == 8'h02) begin
        n_checks++;
        if (bus_rdata !== m_status()) begin
          n_fail++;
          $display("FAIL R2 model status: actual %02h expected %02h at %0t", bus_rdata, m_status(), $time);
        end
      end
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0; bus_addr = 8'h02;
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [7:0] exp);
    bus_addr = a;
    @(negedge clk);
    chk(req, bus_rdata, exp);
    #1 bus_addr = 8'h02;
  endtask

  task automatic pin(input int ch, input logic v);
    @(posedge clk); #1;
    pin_in[ch] = v;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    idle(4);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    rd("R1 status", 8'h02, 8'h00);
    rd("R1 ctrl", 8'h03, 8'h00);
    rd("R1 rise mask p0", 8'h42, 8'h00);
    rd("R1 fall mask p3", 8'h73, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);

    // R4 masks: ch3 rise (port0 bit3), ch21 fall (port2 bit5)
    wr(8'h42, 8'h08);
    wr(8'h63, 8'h20);
    rd("R4 rise p0", 8'h42, 8'h08);
    rd("R4 fall p2", 8'h63, 8'h20);
    rd("R4 fall p0", 8'h43, 8'h00);

    wr(8'h03, 8'h1D);
    rd("R9 ctrl readback", 8'h03, 8'h1D);
    pin(3, 1'b1);
    idle(1);
    rd("R2 not before third edge", 8'h02, 8'h00);
    idle(3);
    rd("R2 rise event", 8'h02, 8'h0D);
    chk("R2 irq", {7'd0, irq}, 8'h01);

    wr(8'h01, 8'h08);
    rd("R7 edge ack", 8'h02, 8'h00);

    pin(3, 1'b0); idle(4);
    rd("R5 unarmed polarity", 8'h02, 8'h00);
    pin(4, 1'b1); idle(4);
    rd("R5 unmasked channel", 8'h02, 8'h00);
    pin(21, 1'b1); idle(4);
    rd("R5 rise on fall-only ch", 8'h02, 8'h00);
    pin(21, 1'b0); idle(4);
    rd("R3 fall event ch21", 8'h02, 8'h15);

    pin(3, 1'b1); idle(4);
    rd("R6 overflow", 8'h02, 8'h0F);

    wr(8'h01, 8'hF3);
    rd("R7 other bits ignored", 8'h02, 8'h0F);
    wr(8'h01, 8'h08);
    rd("R7 edge ack keeps ovf, R8 ovf masked", 8'h02, 8'h02);
    chk("R8 irq low", {7'd0, irq}, 8'h00);
    wr(8'h03, 8'h1F);
    rd("R8 ovf enabled", 8'h02, 8'h06);
    chk("R8 irq high", {7'd0, irq}, 8'h01);
    wr(8'h01, 8'h04);
    rd("R7 ovf ack", 8'h02, 8'h00);

    pin(3, 1'b0); pin(3, 1'b1); idle(4);
    rd("R2 rise again", 8'h02, 8'h0D);
    wr(8'h03, 8'h00);
    rd("R9 irq dropped, pending kept", 8'h02, 8'h09);
    chk("R9 irq", {7'd0, irq}, 8'h00);
    pin(3, 1'b0); pin(3, 1'b1); idle(4);
    rd("R9 detection stopped", 8'h02, 8'h09);

    wr(8'h01, 8'h08);
    wr(8'h03, 8'h15);
    pin(3, 1'b0); pin(3, 1'b1); idle(4);
    rd("R5 global rise off", 8'h02, 8'h00);
    pin(21, 1'b1); pin(21, 1'b0); idle(4);
    rd("R3 fall with rise off", 8'h02, 8'h15);

    idle(2);
    finish_run();
  end
endmodule